// File: doc/BRIEF.md
# Reorder Buffer with Misprediction Flush

This block keeps instructions in program order between issue and retirement in an out-of-order core. Each issued instruction claims the slot at the tail of a small circular buffer, and the index of that slot is handed back as a tag. Execution units later broadcast results carrying the tag. The slot holds the destination register, the result value, the memory address of a store, and the predicted and resolved outcome and target of a branch or jump.

Each cycle the entry at the head is examined. If its result is present, it retires: an ordinary or load result drives a register-file write, and a store drives a memory write. A branch or jump drives an update request toward the branch target buffer. When the resolved outcome differs from the prediction, the block cancels every younger entry and redirects fetch. A no-op or halt is complete on issue. Retiring a halt freezes the block.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, `commit_valid` is 0, `flush` is 0 and `halted` is 0.
- R2: An accepted allocation takes the slot shown on `alloc_tag`. Tags advance 0,1,...,DEPTH-1,0. With DEPTH (6) entries occupied, `alloc_ready` is 0.
- R3: An allocation request made while `alloc_ready` is 0 is dropped and never retires.
- R4: At most one entry retires per cycle, always the oldest. A ready younger entry waits while the oldest entry is not ready.
- R5: Retiring kind ALU (code 0) or LOAD (code 1) raises `commit_reg_we`, with the entry's destination on `commit_reg_idx` and its value on `commit_reg_data`.
- R6: Retiring kind STORE (code 2) raises `commit_mem_we`, with the broadcast address and value on `commit_mem_addr` and `commit_mem_data`, and does not write a register.
- R7: Kinds NOP (code 5) and HALT (code 6) are ready at allocation. At the head, such an entry retires in the cycle right after the allocation edge.
- R8: A result broadcast in one cycle makes its entry eligible to retire only from the next cycle.
- R9: A BRANCH (code 3) predicted not taken and resolved taken raises `flush` as it retires, with `redirect_pc` equal to the resolved target. No younger entry then retires, and the next tag handed out is the branch's slot plus one, modulo DEPTH.
- R10: A BRANCH predicted taken and resolved not taken raises `flush` with `redirect_pc` equal to the branch PC plus 4.
- R11: Every retiring BRANCH or JUMP (code 4) raises `pred_upd_valid`, with its PC, its resolved target and its outcome. A JUMP's outcome is always taken, whatever the broadcast says.
- R12: Retiring a HALT sets `halted`. Once set, `halted` stays set, and nothing further is allocated or retired.
- R13: A result broadcast whose tag names a free slot is ignored. An entry allocated into that slot later still waits for its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue requests a slot |
| alloc_kind | input | 3 | Kind: 0 ALU, 1 LOAD, 2 STORE, 3 BRANCH, 4 JUMP, 5 NOP, 6 HALT |
| alloc_dest | input | RIDX_W | Destination register |
| alloc_pc | input | XLEN | Instruction address |
| alloc_pred_taken | input | 1 | Fetch-time prediction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | TAG_W | Slot index given to the request |
| wb_valid | input | 1 | Result broadcast present |
| wb_tag | input | TAG_W | Slot the broadcast targets |
| wb_value | input | XLEN | Result, or store data |
| wb_addr | input | XLEN | Store address |
| wb_taken | input | 1 | Resolved branch outcome |
| wb_target | input | XLEN | Resolved branch target |
| commit_valid | output | 1 | An entry retires this cycle |
| commit_reg_we | output | 1 | Register write |
| commit_reg_idx | output | RIDX_W | Register written |
| commit_reg_data | output | XLEN | Value written |
| commit_mem_we | output | 1 | Memory write |
| commit_mem_addr | output | XLEN | Memory address |
| commit_mem_data | output | XLEN | Memory data |
| flush | output | 1 | Misprediction: younger entries cancelled |
| redirect_pc | output | XLEN | Fetch restart address, valid with flush |
| pred_upd_valid | output | 1 | Predictor update request |
| pred_upd_pc | output | XLEN | Branch address |
| pred_upd_target | output | XLEN | Resolved target |
| pred_upd_taken | output | 1 | Resolved outcome |
| halted | output | 1 | Halt has retired |

## Verification
The assertions check several properties on every cycle. Occupancy never exceeds DEPTH. A full buffer refuses allocation. Tags step by one after each accepted allocation. At most one of the register, memory and predictor actions fires. A flush always comes with a predictor update whose outcome selects the redirect address. `halted` is sticky and silences the block. Other properties only show up in the bench's scenarios: retirement waits on a non-ready head, a result takes effect one cycle late, cancelled entries never retire, a stray broadcast to a free slot is discarded, and the tail position is correct after a flush.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        OP_ALU    = 3'd0,
        OP_LOAD   = 3'd1,
        OP_STORE  = 3'd2,
        OP_BRANCH = 3'd3,
        OP_JUMP   = 3'd4,
        OP_NOP    = 3'd5,
        OP_HALT   = 3'd6
    } op_kind_e;

endpackage

// File: rtl/rob_wb_match.sv
module rob_wb_match #(
    parameter int DEPTH = 6,
    parameter int TAG_W = 3
) (
    input  logic             wb_valid,
    input  logic [TAG_W-1:0] wb_tag,
    input  logic [DEPTH-1:0] slot_valid,
    output logic [DEPTH-1:0] slot_hit
);

    // One comparator per slot. A broadcast to a free slot hits nothing.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_hit[g] = wb_valid && slot_valid[g] && (wb_tag == TAG_W'(g));
    end

endmodule

// File: rtl/rob_retire_dec.sv
module rob_retire_dec
    import rob_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            head_valid,
    input  logic            head_ready,
    input  op_kind_e        head_kind,
    input  logic [XLEN-1:0] head_pc,
    input  logic            head_pred,
    input  logic            head_taken,
    input  logic [XLEN-1:0] head_target,
    input  logic            halted_q,
    output logic            retire,
    output logic            reg_we,
    output logic            mem_we,
    output logic            ctl_upd,
    output logic            actual_taken,
    output logic            mispredict,
    output logic [XLEN-1:0] restart_pc,
    output logic            halt_now
);

    logic is_ctl;

    always_comb begin
        retire       = head_valid && head_ready && !halted_q;
        is_ctl       = (head_kind == OP_BRANCH) || (head_kind == OP_JUMP);
        // A jump always transfers control, whatever was broadcast.
        actual_taken = (head_kind == OP_JUMP) ? 1'b1 : head_taken;
        reg_we       = retire && ((head_kind == OP_ALU) || (head_kind == OP_LOAD));
        mem_we       = retire && (head_kind == OP_STORE);
        ctl_upd      = retire && is_ctl;
        mispredict   = ctl_upd && (actual_taken != head_pred);
        restart_pc   = actual_taken ? head_target : head_pc + XLEN'(4);
        halt_now     = retire && (head_kind == OP_HALT);
    end

endmodule

// File: rtl/rob_ring_ctrl.sv
module rob_ring_ctrl #(
    parameter int DEPTH = 6,
    parameter int TAG_W = 3,
    parameter int CNT_W = 3
) (
    input  logic [TAG_W-1:0] head_q,
    input  logic [TAG_W-1:0] tail_q,
    input  logic [CNT_W-1:0] count_q,
    input  logic             halted_q,
    input  logic             alloc_req,
    input  logic             retire,
    input  logic             flush,
    output logic             alloc_ready,
    output logic             alloc_ok,
    output logic [TAG_W-1:0] head_d,
    output logic [TAG_W-1:0] tail_d,
    output logic [CNT_W-1:0] count_d
);

    function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(DEPTH - 1)) ? '0 : p + TAG_W'(1);
    endfunction

    always_comb begin
        alloc_ready = (count_q != CNT_W'(DEPTH)) && !halted_q && !flush;
        alloc_ok    = alloc_req && alloc_ready;
        head_d      = retire ? step(head_q) : head_q;
        if (flush) begin
            // Everything younger than the retiring branch is gone.
            tail_d  = step(head_q);
            count_d = '0;
        end else begin
            tail_d  = alloc_ok ? step(tail_q) : tail_q;
            count_d = count_q;
            if (alloc_ok && !retire) begin
                count_d = count_q + CNT_W'(1);
            end else if (!alloc_ok && retire) begin
                count_d = count_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
    import rob_pkg::*;
#(
    parameter int  DEPTH  = 6,
    parameter int  XLEN   = 32,
    parameter int  RIDX_W = 5,
    localparam int TAG_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [2:0]        alloc_kind,
    input  logic [RIDX_W-1:0] alloc_dest,
    input  logic [XLEN-1:0]   alloc_pc,
    input  logic              alloc_pred_taken,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [XLEN-1:0]   wb_value,
    input  logic [XLEN-1:0]   wb_addr,
    input  logic              wb_taken,
    input  logic [XLEN-1:0]   wb_target,
    output logic              commit_valid,
    output logic              commit_reg_we,
    output logic [RIDX_W-1:0] commit_reg_idx,
    output logic [XLEN-1:0]   commit_reg_data,
    output logic              commit_mem_we,
    output logic [XLEN-1:0]   commit_mem_addr,
    output logic [XLEN-1:0]   commit_mem_data,
    output logic              flush,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              pred_upd_valid,
    output logic [XLEN-1:0]   pred_upd_pc,
    output logic [XLEN-1:0]   pred_upd_target,
    output logic              pred_upd_taken,
    output logic              halted
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              valid;
        logic              ready;
        op_kind_e          kind;
        logic [RIDX_W-1:0] dest;
        logic [XLEN-1:0]   pc;
        logic              pred_taken;
        logic [XLEN-1:0]   value;
        logic [XLEN-1:0]   addr;
        logic              taken;
        logic [XLEN-1:0]   target;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic [TAG_W-1:0]   head;
        logic [TAG_W-1:0]   tail;
        logic [CNT_W-1:0]   count;
        logic               halted;
    } state_t;

    state_t state_q, state_d;

    entry_t           head_ent;
    op_kind_e         new_kind;
    logic [DEPTH-1:0] slot_valid;
    logic [DEPTH-1:0] slot_hit;
    logic             retire, reg_we, mem_we, ctl_upd, actual_taken;
    logic             mispredict, halt_now, alloc_ok;
    logic [XLEN-1:0]  restart_pc;
    logic [TAG_W-1:0] head_n, tail_n;
    logic [CNT_W-1:0] count_n;

    assign head_ent = state_q.ent[state_q.head];
    assign new_kind = op_kind_e'(alloc_kind);

    for (genvar g = 0; g < DEPTH; g++) begin : g_valid
        assign slot_valid[g] = state_q.ent[g].valid;
    end

    rob_wb_match #(
        .DEPTH (DEPTH),
        .TAG_W (TAG_W)
    ) i_wb_match (
        .wb_valid   (wb_valid),
        .wb_tag     (wb_tag),
        .slot_valid (slot_valid),
        .slot_hit   (slot_hit)
    );

    rob_retire_dec #(
        .XLEN (XLEN)
    ) i_retire_dec (
        .head_valid   (head_ent.valid),
        .head_ready   (head_ent.ready),
        .head_kind    (head_ent.kind),
        .head_pc      (head_ent.pc),
        .head_pred    (head_ent.pred_taken),
        .head_taken   (head_ent.taken),
        .head_target  (head_ent.target),
        .halted_q     (state_q.halted),
        .retire       (retire),
        .reg_we       (reg_we),
        .mem_we       (mem_we),
        .ctl_upd      (ctl_upd),
        .actual_taken (actual_taken),
        .mispredict   (mispredict),
        .restart_pc   (restart_pc),
        .halt_now     (halt_now)
    );

    rob_ring_ctrl #(
        .DEPTH (DEPTH),
        .TAG_W (TAG_W),
        .CNT_W (CNT_W)
    ) i_ring_ctrl (
        .head_q      (state_q.head),
        .tail_q      (state_q.tail),
        .count_q     (state_q.count),
        .halted_q    (state_q.halted),
        .alloc_req   (alloc_valid),
        .retire      (retire),
        .flush       (mispredict),
        .alloc_ready (alloc_ready),
        .alloc_ok    (alloc_ok),
        .head_d      (head_n),
        .tail_d      (tail_n),
        .count_d     (count_n)
    );

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_hit[i]) begin
                state_d.ent[i].ready  = 1'b1;
                state_d.ent[i].value  = wb_value;
                state_d.ent[i].addr   = wb_addr;
                state_d.ent[i].taken  = wb_taken;
                state_d.ent[i].target = wb_target;
            end
        end
        if (retire) begin
            state_d.ent[state_q.head].valid = 1'b0;
        end
        if (mispredict) begin
            for (int i = 0; i < DEPTH; i++) begin
                state_d.ent[i].valid = 1'b0;
            end
        end
        if (alloc_ok) begin
            state_d.ent[state_q.tail].valid      = 1'b1;
            state_d.ent[state_q.tail].ready      = (new_kind == OP_NOP) || (new_kind == OP_HALT);
            state_d.ent[state_q.tail].kind       = new_kind;
            state_d.ent[state_q.tail].dest       = alloc_dest;
            state_d.ent[state_q.tail].pc         = alloc_pc;
            state_d.ent[state_q.tail].pred_taken = alloc_pred_taken;
            state_d.ent[state_q.tail].value      = '0;
            state_d.ent[state_q.tail].addr       = '0;
            state_d.ent[state_q.tail].taken      = 1'b0;
            state_d.ent[state_q.tail].target     = '0;
        end
        state_d.head   = head_n;
        state_d.tail   = tail_n;
        state_d.count  = count_n;
        state_d.halted = state_q.halted || halt_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign alloc_tag       = state_q.tail;
    assign commit_valid    = retire;
    assign commit_reg_we   = reg_we;
    assign commit_reg_idx  = head_ent.dest;
    assign commit_reg_data = head_ent.value;
    assign commit_mem_we   = mem_we;
    assign commit_mem_addr = head_ent.addr;
    assign commit_mem_data = head_ent.value;
    assign flush           = mispredict;
    assign redirect_pc     = restart_pc;
    assign pred_upd_valid  = ctl_upd;
    assign pred_upd_pc     = head_ent.pc;
    assign pred_upd_target = head_ent.target;
    assign pred_upd_taken  = actual_taken;
    assign halted          = state_q.halted;

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int DEPTH = 6,
    parameter int XLEN  = 32,
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             commit_valid,
    input logic             commit_reg_we,
    input logic             commit_mem_we,
    input logic             flush,
    input logic [XLEN-1:0]  redirect_pc,
    input logic             pred_upd_valid,
    input logic [XLEN-1:0]  pred_upd_pc,
    input logic [XLEN-1:0]  pred_upd_target,
    input logic             pred_upd_taken,
    input logic             halted
);

    localparam int OCC_W = $clog2(DEPTH + 2);

    function automatic logic [TAG_W-1:0] next_tag(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(DEPTH - 1)) ? '0 : p + TAG_W'(1);
    endfunction

    // Occupancy rebuilt from the port traffic alone.
    logic [OCC_W-1:0] occ;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else if (flush) begin
            occ <= '0;
        end else begin
            occ <= occ + OCC_W'(alloc_valid && alloc_ready) - OCC_W'(commit_valid);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH)); // R2
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_W'(DEPTH)) |-> !alloc_ready); // R2
    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=> (alloc_tag == next_tag($past(alloc_tag)))); // R2
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_reg_we, commit_mem_we, pred_upd_valid})); // R6
    AST_ACTION_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_reg_we || commit_mem_we || pred_upd_valid) |-> commit_valid); // R4
    AST_FLUSH_FROM_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> pred_upd_valid); // R9
    AST_TAKEN_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && pred_upd_taken) |-> (redirect_pc == pred_upd_target)); // R9
    AST_FALLTHRU_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !pred_upd_taken) |-> (redirect_pc == pred_upd_pc + XLEN'(4))); // R10
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R12
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!commit_valid && !alloc_ready)); // R12

endmodule

bind reorder_buf rob_checker #(
    .DEPTH (DEPTH),
    .XLEN  (XLEN),
    .TAG_W (TAG_W)
) i_rob_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .alloc_valid     (alloc_valid),
    .alloc_ready     (alloc_ready),
    .alloc_tag       (alloc_tag),
    .commit_valid    (commit_valid),
    .commit_reg_we   (commit_reg_we),
    .commit_mem_we   (commit_mem_we),
    .flush           (flush),
    .redirect_pc     (redirect_pc),
    .pred_upd_valid  (pred_upd_valid),
    .pred_upd_pc     (pred_upd_pc),
    .pred_upd_target (pred_upd_target),
    .pred_upd_taken  (pred_upd_taken),
    .halted          (halted)
);

// File: tb/test_reorder_buf.sv
module test_reorder_buf;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [2:0]  alloc_kind = '0;
    logic [4:0]  alloc_dest = '0;
    logic [31:0] alloc_pc = '0;
    logic        alloc_pred_taken = 1'b0;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic        wb_valid = 1'b0;
    logic [2:0]  wb_tag = '0;
    logic [31:0] wb_value = '0;
    logic [31:0] wb_addr = '0;
    logic        wb_taken = 1'b0;
    logic [31:0] wb_target = '0;
    logic        commit_valid, commit_reg_we, commit_mem_we, flush;
    logic [4:0]  commit_reg_idx;
    logic [31:0] commit_reg_data, commit_mem_addr, commit_mem_data, redirect_pc;
    logic        pred_upd_valid, pred_upd_taken, halted;
    logic [31:0] pred_upd_pc, pred_upd_target;

    always #(PERIOD / 2) clk = ~clk;

    reorder_buf i_reorder_buf (.*);

    typedef struct {
        int          kind;
        int          dest;
        logic [31:0] pc;
        bit          pred;
        bit          ready;
        logic [31:0] value;
        logic [31:0] addr;
        bit          taken;
        logic [31:0] target;
        int          tag;
    } ment_t;

    ment_t mq[$];
    int    m_tail = 0;
    int    m_head = 0;
    bit    m_halted = 1'b0;
    int    n_checks = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    bit          e_commit, e_flush, e_upd, e_act, e_ready;
    int          e_kind;
    logic [31:0] e_rpc;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic predict();
        e_commit = !m_halted && (mq.size() > 0) && mq[0].ready;
        e_kind   = (mq.size() > 0) ? mq[0].kind : 0;
        e_upd    = e_commit && (e_kind == 3 || e_kind == 4);
        e_act    = (e_kind == 4) ? 1'b1 : ((mq.size() > 0) ? mq[0].taken : 1'b0);
        e_flush  = e_upd && (e_act != mq[0].pred);
        e_rpc    = (mq.size() == 0) ? 32'h0 : (e_act ? mq[0].target : mq[0].pc + 32'd4);
        e_ready  = (mq.size() < DEPTH) && !m_halted && !e_flush;
    endtask

    task automatic compare_all();
        predict();
        chk(alloc_ready == e_ready, "R2 alloc_ready", 32'(alloc_ready), 32'(e_ready));
        if (e_ready) chk(alloc_tag == 3'(m_tail), "R2 alloc_tag", 32'(alloc_tag), 32'(m_tail));
        chk(commit_valid == e_commit, "R4 commit_valid", 32'(commit_valid), 32'(e_commit));
        chk(commit_reg_we == (e_commit && e_kind <= 1), "R5 reg_we", 32'(commit_reg_we), 32'(e_commit && e_kind <= 1));
        if (e_commit && e_kind <= 1) begin
            chk(commit_reg_idx == 5'(mq[0].dest), "R5 reg_idx", 32'(commit_reg_idx), 32'(mq[0].dest));
            chk(commit_reg_data == mq[0].value, "R5 reg_data", commit_reg_data, mq[0].value);
        end
        chk(commit_mem_we == (e_commit && e_kind == 2), "R6 mem_we", 32'(commit_mem_we), 32'(e_commit && e_kind == 2));
        if (e_commit && e_kind == 2) begin
            chk(commit_mem_addr == mq[0].addr, "R6 mem_addr", commit_mem_addr, mq[0].addr);
            chk(commit_mem_data == mq[0].value, "R6 mem_data", commit_mem_data, mq[0].value);
        end
        chk(flush == e_flush, "R9 flush", 32'(flush), 32'(e_flush));
        if (e_flush) chk(redirect_pc == e_rpc, e_act ? "R9 redirect" : "R10 redirect", redirect_pc, e_rpc);
        chk(pred_upd_valid == e_upd, "R11 upd_valid", 32'(pred_upd_valid), 32'(e_upd));
        if (e_upd) begin
            chk(pred_upd_pc == mq[0].pc, "R11 upd_pc", pred_upd_pc, mq[0].pc);
            chk(pred_upd_target == mq[0].target, "R11 upd_target", pred_upd_target, mq[0].target);
            chk(pred_upd_taken == e_act, "R11 upd_taken", 32'(pred_upd_taken), 32'(e_act));
        end
        chk(halted == m_halted, "R12 halted", 32'(halted), 32'(m_halted));
    endtask

    task automatic model_step();
        ment_t n;
        if (e_commit) begin
            void'(mq.pop_front());
            m_head = (m_head + 1) % DEPTH;
            if (e_kind == 6) m_halted = 1'b1;
        end
        if (wb_valid) begin
            foreach (mq[i]) begin
                if (mq[i].tag == int'(wb_tag)) begin
                    mq[i].ready  = 1'b1;
                    mq[i].value  = wb_value;
                    mq[i].addr   = wb_addr;
                    mq[i].taken  = wb_taken;
                    mq[i].target = wb_target;
                end
            end
        end
        if (e_flush) begin
            mq.delete();
            m_tail = m_head;
        end
        if (alloc_valid && e_ready) begin
            n.kind = int'(alloc_kind); n.dest = int'(alloc_dest); n.pc = alloc_pc;
            n.pred = alloc_pred_taken; n.ready = (alloc_kind == 5 || alloc_kind == 6);
            n.value = '0; n.addr = '0; n.taken = 1'b0; n.target = '0; n.tag = m_tail;
            mq.push_back(n);
            m_tail = (m_tail + 1) % DEPTH;
        end
    endtask

    task automatic tick();
        compare_all();
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_alloc(input int kind, input int dest, input int pc, input bit pred, output int tag);
        tag = int'(alloc_tag);
        alloc_valid = 1'b1; alloc_kind = 3'(kind); alloc_dest = 5'(dest);
        alloc_pc = 32'(pc); alloc_pred_taken = pred;
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic set_wb(input int tag, input int val, input int addr, input bit tk, input int tgt);
        wb_valid = 1'b1; wb_tag = 3'(tag); wb_value = 32'(val);
        wb_addr = 32'(addr); wb_taken = tk; wb_target = 32'(tgt);
    endtask

    task automatic do_wb(input int tag, input int val, input int addr, input bit tk, input int tgt);
        set_wb(tag, val, addr, tk, tgt);
        tick();
        wb_valid = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        int t0, t1, t2, t3, tb, ty, tz;
        int full_tags[6];
        bit saw9;
        repeat (3) @(negedge clk);
        // R1: state after reset
        chk(alloc_ready == 1'b1, "R1 alloc_ready", 32'(alloc_ready), 1);
        chk(alloc_tag == 3'd0, "R1 alloc_tag", 32'(alloc_tag), 0);
        chk(commit_valid == 1'b0, "R1 commit_valid", 32'(commit_valid), 0);
        chk(flush == 1'b0, "R1 flush", 32'(flush), 0);
        chk(halted == 1'b0, "R1 halted", 32'(halted), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Mixed kinds; the head blocks a ready younger entry (R4), R5, R6, R8
        do_alloc(0, 3, 600, 0, t0);
        do_alloc(1, 4, 604, 0, t1);
        do_alloc(2, 0, 608, 0, t2);
        do_alloc(5, 0, 612, 0, t3);
        chk(commit_valid == 1'b0, "R4 head not ready", 32'(commit_valid), 0);
        do_wb(t1, 77, 0, 0, 0);
        chk(commit_valid == 1'b0, "R4 younger ready waits", 32'(commit_valid), 0);
        set_wb(t0, 55, 0, 0, 0);
        chk(commit_valid == 1'b0, "R8 same-cycle result invisible", 32'(commit_valid), 0);
        tick();
        wb_valid = 1'b0;
        chk(commit_valid && commit_reg_data == 32'd55, "R8 result next cycle", commit_reg_data, 55);
        do_wb(t2, 99, 724, 0, 0);
        run(4);

        // R7: a NOP at an empty head retires right after allocation
        do_alloc(5, 0, 616, 0, t0);
        chk(commit_valid == 1'b1, "R7 nop ready at issue", 32'(commit_valid), 1);
        run(1);

        // R13: stray broadcast to a free slot
        t1 = int'(alloc_tag);
        do_wb(t1, 1234, 0, 0, 0);
        do_alloc(0, 5, 620, 0, t2);
        chk(commit_valid == 1'b0, "R13 stray result ignored", 32'(commit_valid), 0);
        run(2);
        chk(commit_valid == 1'b0, "R13 entry still waiting", 32'(commit_valid), 0);
        do_wb(t2, 8, 0, 0, 0);
        run(1);

        // R2/R3: fill, reject, drain in reverse result order
        for (int i = 0; i < DEPTH; i++) do_alloc(0, i + 1, 624 + 4 * i, 0, full_tags[i]);
        chk(alloc_ready == 1'b0, "R2 full", 32'(alloc_ready), 0);
        do_alloc(0, 9, 700, 0, t0);
        for (int i = DEPTH - 1; i >= 0; i--) do_wb(full_tags[i], 100 + i, 0, 0, 0);
        saw9 = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (commit_reg_we && commit_reg_idx == 5'd9) saw9 = 1'b1;
            tick();
        end
        chk(saw9 == 1'b0, "R3 rejected request never retires", 32'(saw9), 0);

        // R9: predicted not taken, resolved taken
        do_alloc(3, 0, 640, 0, tb);
        do_alloc(0, 7, 644, 0, ty);
        do_alloc(0, 8, 648, 0, tz);
        do_wb(ty, 1, 0, 0, 0);
        do_wb(tz, 2, 0, 0, 0);
        do_wb(tb, 0, 0, 1, 700);
        chk(flush && redirect_pc == 32'd700, "R9 redirect target", redirect_pc, 700);
        tick();
        chk(commit_valid == 1'b0, "R9 younger cancelled", 32'(commit_valid), 0);
        chk(alloc_tag == 3'((tb + 1) % DEPTH), "R9 tail after flush", 32'(alloc_tag), 32'((tb + 1) % DEPTH));
        run(2);

        // R10: predicted taken, resolved not taken
        do_alloc(3, 0, 650, 1, tb);
        do_alloc(1, 9, 654, 0, ty);
        do_wb(ty, 3, 0, 0, 0);
        do_wb(tb, 0, 0, 0, 800);
        chk(flush && redirect_pc == 32'd654, "R10 redirect fall-through", redirect_pc, 654);
        run(2);

        // R11: correct prediction, then a jump whose broadcast says not taken
        do_alloc(3, 0, 660, 1, tb);
        do_wb(tb, 0, 0, 1, 680);
        chk(pred_upd_valid && !flush && pred_upd_taken, "R11 correct branch update", 32'(flush), 0);
        run(1);
        do_alloc(4, 0, 670, 0, tb);
        do_alloc(0, 2, 674, 0, ty);
        do_wb(tb, 0, 0, 0, 612);
        chk(pred_upd_valid && pred_upd_taken && flush && redirect_pc == 32'd612,
            "R11 jump forced taken", redirect_pc, 612);
        run(2);

        // R12: halt freezes everything
        do_alloc(6, 0, 690, 0, t0);
        chk(commit_valid == 1'b1, "R7 halt ready at issue", 32'(commit_valid), 1);
        alloc_valid = 1'b1; alloc_kind = 3'd0; alloc_dest = 5'd6; alloc_pc = 32'd694;
        tick();
        alloc_valid = 1'b0;
        chk(halted == 1'b1, "R12 halted set", 32'(halted), 1);
        do_wb(int'(alloc_tag), 5, 0, 0, 0);
        run(3);
        chk(halted && !commit_valid && !alloc_ready, "R12 frozen", 32'(commit_valid), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule